// File: doc/BRIEF.md
# Scrambled-Map Interrupt Controller

This block gathers up to 64 active-low interrupt lines into one interrupt output. Software reaches it over a simple 32-bit register bus with word addressing. The bus has no handshake and no back-pressure: a write takes effect on the clock edge where `bus_wr` is high, and read data follows the address combinationally. Enable and pending state for the 64 sources is split across a low word and a high word. The bit that each source occupies comes from a fixed scrambled table, not from its source number.

Each line passes through a synchronizer. Most sources are level sensitive, so their pending bit follows the line. Some external and port sources can instead be set to latch on a falling edge, through the edge-select register. When the output is raised, a vector register names the lowest-numbered source that is both pending and enabled. Sources 0 and 31 are reserved. Source 0 is reserved because vector value 0 means that nothing is pending. Source 31 is reserved because its table slot falls on the same bit as source 18.

Register word addresses: 0 enable-low, 1 enable-high, 2 pending-low, 3 pending-high, 4 vector, 5 edge-select. Any other address reads 0.

Top module: `scram_intc`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Sources 1–15 and 32–47 sit in the low word; sources 16–30 and 48–63 sit in the high word. Bit positions are as follows:
  - source 0 is bit 0, and source s from 1 to 15 is bit 16−s;
  - sources 16, 17 and 18 are bits 2, 1 and 0, and source s from 19 to 30 is bit 33−s;
  - source s from 32 to 47 is bit 63−s, and source s from 48 to 63 is bit s−32.
  The same placement is used for both the enable words and the pending words.
- R3: An enable bit of 1 enables its source. The enable words read back what was written. `irq_o` is high exactly when some source is both pending and enabled.
- R4: Writing a pending word clears each edge-latched bit whose data bit is 1. Bits written with 0 keep their value.
- R5: A level source's pending bit is 1 while its synchronized line is low. Writing 1 to that bit has no lasting effect while the line stays low.
- R6: An edge source's pending bit is set by a falling edge of its synchronized line. It stays set after the line returns high, until software clears it.
- R7: The vector register holds, in bits 31:26, the lowest-numbered source that is pending and enabled. All other bits read 0, and the whole register reads 0 when no source qualifies. Writes to the vector register are ignored.
- R8: Edge select applies to sources 19–25, which use bit 33−s, and to sources 48–63, which use bit 79−s. A bit of 1 selects falling-edge latching. Only those bits (mask 0xFFFF7F00) can be written; all other bits read 0.
- R9: Sources 0 and 31 never become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_n | input | 64 | Active-low interrupt lines, index = source number |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default `SYNC_STAGES` of 2. With that setting, a change on a line reaches the pending word three edges later, so a short settling wait is enough before every read. This setting covers the full scrambled map: both word boundaries, the reversed and the ascending runs, and the three-bit run at sources 16–18. It also lets the bench check edge latching, held pending bits, and priority between the low and high words.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC = 64;
  localparam int DW   = 32;
  localparam int IDW  = 6;

  // word select: 1 = high word
  function automatic logic src_word(input logic [5:0] s);
    return s[4];
  endfunction

  function automatic logic [4:0] src_bit(input logic [5:0] s);
    int v;
    v = int'(s);
    if (v == 0)       return 5'd0;
    else if (v < 16)  return 5'(16 - v);
    else if (v < 19)  return 5'(18 - v);
    else if (v < 31)  return 5'(33 - v);
    else if (v == 31) return 5'd0;
    else if (v < 48)  return 5'(63 - v);
    else              return 5'(v - 32);
  endfunction

  function automatic logic reserved_src(input logic [5:0] s);
    return (s == 6'd0) || (s == 6'd31);
  endfunction

  function automatic logic edge_ok(input logic [5:0] s);
    return (s >= 6'd19 && s <= 6'd25) || (s >= 6'd48);
  endfunction

  function automatic logic [4:0] edge_bit(input logic [5:0] s);
    int v;
    v = int'(s);
    if (v >= 48)      return 5'(79 - v);
    else if (v >= 19 && v <= 25) return 5'(33 - v);
    else              return 5'd0;
  endfunction

  function automatic logic [DW-1:0] edge_cap_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < NSRC; s++)
      if (edge_ok(6'(s))) m[edge_bit(6'(s))] = 1'b1;
    return m;
  endfunction

  typedef enum logic [2:0] {
    A_EN_LO  = 3'd0,
    A_EN_HI  = 3'd1,
    A_PND_LO = 3'd2,
    A_PND_HI = 3'd3,
    A_VEC    = 3'd4,
    A_EDGE   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '1;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/intc_pend.sv
module intc_pend
  import intc_pkg::*;
#(
  parameter int W = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_n,
  input  logic [W-1:0] edge_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= line_n;
  end

  for (genvar i = 0; i < W; i++) begin : g_src
    localparam bit RSV = reserved_src(6'(i));
    assign fall[i] = prev[i] & ~line_n[i];
    if (RSV) begin : g_rsv
      assign pend[i] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (rst)             pend[i] <= 1'b0;
        else if (edge_en[i]) pend[i] <= fall[i] | (pend[i] & ~clr[i]);
        else                 pend[i] <= ~line_n[i];
      end
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int W   = 64,
  parameter int IDW = $clog2(W)
) (
  input  logic [W-1:0]   act,
  output logic [IDW-1:0] id
);
  always_comb begin
    id = '0;
    for (int i = W - 1; i >= 0; i--)
      if (act[i]) id = IDW'(i);
  end
endmodule

// File: rtl/scram_intc.sv
module scram_intc
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_n,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam logic [DW-1:0] EDGE_CAP = edge_cap_mask();

  logic [DW-1:0]   en_lo, en_hi, edge_reg;
  logic [DW-1:0]   pnd_lo, pnd_hi;
  logic [NSRC-1:0] line_n, pend, fall, clr, edge_en, en, act;
  logic [IDW-1:0]  vec_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_lo    <= '0;
      en_hi    <= '0;
      edge_reg <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_EN_LO: en_lo    <= bus_wdata;
        A_EN_HI: en_hi    <= bus_wdata;
        A_EDGE:  edge_reg <= bus_wdata & EDGE_CAP;
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    localparam logic     WSEL = src_word(6'(s));
    localparam int       B    = int'(src_bit(6'(s)));
    localparam int       EB   = int'(edge_bit(6'(s)));
    localparam bit       ECAP = edge_ok(6'(s));
    assign en[s]  = WSEL ? en_hi[B] : en_lo[B];
    assign clr[s] = bus_wr && (bus_addr == (WSEL ? A_PND_HI : A_PND_LO)) && bus_wdata[B];
    if (ECAP) begin : g_edge
      assign edge_en[s] = edge_reg[EB];
    end else begin : g_lvl
      assign edge_en[s] = 1'b0;
    end
  end

  always_comb begin
    pnd_lo = '0;
    pnd_hi = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_word(6'(s))) pnd_hi[src_bit(6'(s))] = pnd_hi[src_bit(6'(s))] | pend[s];
      else                 pnd_lo[src_bit(6'(s))] = pnd_lo[src_bit(6'(s))] | pend[s];
    end
  end

  intc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(src_n), .q(line_n)
  );

  intc_pend #(.W(NSRC)) u_pend (
    .clk(clk), .rst(rst), .line_n(line_n), .edge_en(edge_en),
    .clr(clr), .pend(pend), .fall(fall)
  );

  assign act = pend & en;

  intc_prio #(.W(NSRC), .IDW(IDW)) u_prio (.act(act), .id(vec_id));

  assign irq_o = |act;

  always_comb begin
    case (bus_addr)
      A_EN_LO:  bus_rdata = en_lo;
      A_EN_HI:  bus_rdata = en_hi;
      A_PND_LO: bus_rdata = pnd_lo;
      A_PND_HI: bus_rdata = pnd_hi;
      A_VEC:    bus_rdata = {vec_id, {(DW-IDW){1'b0}}};
      A_EDGE:   bus_rdata = edge_reg;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_o,
  input logic [5:0]  vec_id,
  input logic [63:0] pend,
  input logic [63:0] clr,
  input logic [63:0] fall,
  input logic [63:0] edge_en,
  input logic [31:0] edge_reg
);
  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vec_id != 6'd0));

  // R4
  edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(clr & ~fall & edge_en)) & pend) == 64'd0));

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(fall & edge_en)) & ~pend) == 64'd0));

  // R9
  reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend[0] == 1'b0) && (pend[31] == 1'b0));

  // R8
  edge_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ((edge_reg & ~32'hFFFF7F00) == 32'd0));
endmodule

bind scram_intc intc_chk u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .vec_id(vec_id), .pend(pend),
  .clr(clr), .fall(fall), .edge_en(edge_en), .edge_reg(edge_reg)
);

// File: tb/test_scram_intc.sv
module test_scram_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_n = '1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int fails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scram_intc i_scram_intc (
    .clk(clk), .rst(rst), .src_n(src_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {source, word (1 = high), bit}
  localparam logic [11:0] TBL [10] = '{
    {6'd1,  1'b0, 5'd15}, {6'd15, 1'b0, 5'd1},  {6'd16, 1'b1, 5'd2},
    {6'd18, 1'b1, 5'd0},  {6'd19, 1'b1, 5'd14}, {6'd30, 1'b1, 5'd3},
    {6'd32, 1'b0, 5'd31}, {6'd47, 1'b0, 5'd16}, {6'd48, 1'b1, 5'd16},
    {6'd63, 1'b1, 5'd31}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 32'd0);
    end
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    // R3: enable readback
    wr(3'd0, 32'hFFFFFFFF); wr(3'd1, 32'hFFFFFFFF);
    rd(3'd0, v); chk("R3 en_lo", v, 32'hFFFFFFFF);

    // R2, R7: map table walk with level sources
    for (int k = 0; k < 10; k++) begin
      logic [5:0] s; logic w; logic [4:0] b;
      {s, w, b} = TBL[k];
      src_n[s] = 1'b0; settle();
      rd(w ? 3'd3 : 3'd2, v); chk("R2 bit", v, 32'd1 << b);
      rd(w ? 3'd2 : 3'd3, v); chk("R2 other word", v, 32'd0);
      rd(3'd4, v); chk("R7 vector", v, {s, 26'd0});
      src_n[s] = 1'b1; settle();
    end

    // R7: priority and masking, vector write ignored
    src_n[5] = 1'b0; src_n[40] = 1'b0; settle();
    rd(3'd4, v); chk("R7 lowest", v, {6'd5, 26'd0});
    wr(3'd4, 32'hFFFFFFFF);
    rd(3'd4, v); chk("R7 write ignored", v, {6'd5, 26'd0});
    wr(3'd0, 32'hFFFFFFFF & ~(32'd1 << 11));
    rd(3'd4, v); chk("R7 masked lower", v, {6'd40, 26'd0});
    // R5: level clear has no lasting effect
    wr(3'd2, 32'd1 << 11);
    rd(3'd2, v); chk("R5 level held", v & (32'd1 << 11), 32'd1 << 11);
    // R3: all disabled -> irq low while pending
    wr(3'd0, 32'd0); wr(3'd1, 32'd0);
    @(negedge clk); chk("R3 irq off", {31'd0, irq_o}, 32'd0);
    rd(3'd4, v); chk("R7 none", v, 32'd0);
    src_n[5] = 1'b1; src_n[40] = 1'b1; settle();
    rd(3'd2, v); chk("R5 tracks release", v, 32'd0);

    // R8: writable edge bits
    wr(3'd5, 32'hFFFFFFFF);
    rd(3'd5, v); chk("R8 cap mask", v, 32'hFFFF7F00);
    wr(3'd5, 32'd1 << 13); // source 20
    wr(3'd1, 32'd1 << 13);
    // R6: falling edge latches and holds
    src_n[20] = 1'b0; settle(); src_n[20] = 1'b1; settle();
    rd(3'd3, v); chk("R6 held", v, 32'd1 << 13);
    chk("R3 irq on", {31'd0, irq_o}, 32'd1);
    // R4: write 0 keeps, write 1 clears
    wr(3'd3, 32'd0);
    rd(3'd3, v); chk("R4 zero keeps", v, 32'd1 << 13);
    wr(3'd3, 32'd1 << 13);
    rd(3'd3, v); chk("R4 one clears", v, 32'd0);
    // R8: port source 63 uses edge bit 16
    wr(3'd5, 32'd1 << 16);
    src_n[63] = 1'b0; settle(); src_n[63] = 1'b1; settle();
    rd(3'd3, v); chk("R8 port edge", v, 32'd1 << 31);
    wr(3'd3, 32'hFFFFFFFF);

    // R9: reserved sources
    wr(3'd0, 32'hFFFFFFFF); wr(3'd1, 32'hFFFFFFFF);
    src_n[0] = 1'b0; src_n[31] = 1'b0; settle();
    rd(3'd2, v); chk("R9 low", v, 32'd0);
    rd(3'd3, v); chk("R9 high", v, 32'd0);
    chk("R9 irq", {31'd0, irq_o}, 32'd0);
    src_n[0] = 1'b1; src_n[31] = 1'b1; settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule